// File: doc/BRIEF.md
# Two-Channel Block Copy Engine

This engine moves a block of data from one memory region to another without the processor touching each datum. Two address channels are used together. The source channel supplies the read address, the destination channel supplies the write address, and only the destination channel's down-counter decides how long the copy runs. Each datum crosses the memory port in two bus cycles. A read cycle latches the datum into an internal holding register, and the next cycle writes that register to the destination.

Software sets up the base address and count registers and a mode register while the engine is idle, then issues a start command. A busy flag covers the whole copy. A one-cycle end-of-process pulse marks the final write. If auto-reload is set, both channels return to their programmed base values once the copy ends, so the same copy can be started again without reprogramming. A hold-source option freezes the source address, which fills the destination block with a single value.

Top module: `blkCopyEngine`

## Requirements
- R1: After reset, `busy`, `eop`, `memRd` and `memWr` are low, and every register reads back as zero.
- R2: Register selects: 0 = source address, 1 = source count, 2 = destination address, 3 = destination count, 4 = mode. A write while idle loads both the base value and the current value of the selected register. `regRdData` returns the current value. Register writes made while busy are ignored.
- R3: Each datum takes one read cycle (`memRd`=1, `memAddr` = current source address), followed directly by one write cycle (`memWr`=1, `memAddr` = current destination address, `memWData` = the datum read). `memRd` and `memWr` are never high together.
- R4: Mode bit 0 makes the source address step by -1 instead of +1. Mode bit 1 does the same for the destination address.
- R5: The destination count drops by 1 after each write. The copy ends after the write in which the count wraps from 0 to all ones, so a count of N moves N+1 data.
- R6: `busy` rises in the cycle after an accepted start and stays high until the cycle in which `eop` pulses for exactly one cycle. A copy with count N therefore ends with `eop` 2(N+1) cycles after `busy` first reads high.
- R7: A start command given while busy is ignored and does not lengthen or restart the copy.
- R8: When mode bit 2 (auto-reload) is set, the current addresses and counts of both channels are reloaded from their base values when the copy ends. When it is clear, the destination count reads all ones and the addresses keep their final stepped values.
- R9: When mode bit 3 (hold-source) is set, the source address never changes, so every destination location receives the same value.
- R10: The source address steps only at the end of the read cycle. The destination address and count step only at the end of the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Current value of the selected register |
| start | input | 1 | Start command, taken only when idle |
| memAddr | output | 16 | Memory address |
| memRd | output | 1 | Memory read cycle |
| memWr | output | 1 | Memory write cycle |
| memWData | output | 8 | Write data |
| memRData | input | 8 | Read data, sampled at the end of the read cycle |
| busy | output | 1 | Copy in progress |
| eop | output | 1 | One-cycle end-of-process pulse |

## Verification
The bench builds the engine with its default 16-bit addresses and counts and 8-bit data. It places the source and destination blocks inside a 256-byte model memory that is decoded on the low address byte. With 16-bit counts, the wrap from 0 to all ones (the terminal count) is reached with small programmed values, so the single-datum and short-block boundaries stay cheap to run. Each run is also timed in clock cycles, and the per-cycle address sequencing is examined through the register read port in the middle of a copy.

// File: rtl/copyPkg.sv
package copyPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} copyStateT;

  typedef struct packed {
    logic loadTmp;   // capture read data, step source
    logic stepDst;   // step destination address and count
    logic reload;    // restore currents from bases
    logic phaseWr;   // drive destination address
  } copyStrobeT;

  localparam logic [2:0] SEL_SRC_ADDR = 3'd0;
  localparam logic [2:0] SEL_SRC_CNT  = 3'd1;
  localparam logic [2:0] SEL_DST_ADDR = 3'd2;
  localparam logic [2:0] SEL_DST_CNT  = 3'd3;
  localparam logic [2:0] SEL_MODE     = 3'd4;
endpackage

// File: rtl/copyDatapath.sv
module copyDatapath
  import copyPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idle,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  copyStrobeT        strobe,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] tmpData,
  output logic              lastXfer,
  output logic              autoInit
);
  logic [ADDR_W-1:0] srcBase, srcAddr, dstBase, dstAddr;
  logic [CNT_W-1:0]  srcCntBase, srcCnt, dstCntBase, dstCnt;
  logic [3:0]        mode;
  logic              cfgWr;

  assign cfgWr    = regWrEn && idle;
  assign autoInit = mode[2];
  assign lastXfer = (dstCnt == '0);
  assign memAddr  = strobe.phaseWr ? dstAddr : srcAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcBase <= '0; srcAddr <= '0; dstBase <= '0; dstAddr <= '0;
      srcCntBase <= '0; srcCnt <= '0; dstCntBase <= '0; dstCnt <= '0;
      mode <= '0; tmpData <= '0;
    end else if (cfgWr) begin
      case (regSel)
        SEL_SRC_ADDR: begin srcBase <= ADDR_W'(regWrData); srcAddr <= ADDR_W'(regWrData); end
        SEL_SRC_CNT:  begin srcCntBase <= CNT_W'(regWrData); srcCnt <= CNT_W'(regWrData); end
        SEL_DST_ADDR: begin dstBase <= ADDR_W'(regWrData); dstAddr <= ADDR_W'(regWrData); end
        SEL_DST_CNT:  begin dstCntBase <= CNT_W'(regWrData); dstCnt <= CNT_W'(regWrData); end
        SEL_MODE:     mode <= regWrData[3:0];
        default: ;
      endcase
    end else begin
      if (strobe.loadTmp) begin
        tmpData <= memRData;
        if (!mode[3])
          srcAddr <= mode[0] ? srcAddr - ADDR_W'(1) : srcAddr + ADDR_W'(1);
      end
      if (strobe.reload) begin
        srcAddr <= srcBase;
        dstAddr <= dstBase;
        srcCnt  <= srcCntBase;
        dstCnt  <= dstCntBase;
      end else if (strobe.stepDst) begin
        dstAddr <= mode[1] ? dstAddr - ADDR_W'(1) : dstAddr + ADDR_W'(1);
        dstCnt  <= dstCnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_SRC_ADDR: regRdData = REG_W'(srcAddr);
      SEL_SRC_CNT:  regRdData = REG_W'(srcCnt);
      SEL_DST_ADDR: regRdData = REG_W'(dstAddr);
      SEL_DST_CNT:  regRdData = REG_W'(dstCnt);
      SEL_MODE:     regRdData = REG_W'(mode);
      default:      regRdData = '0;
    endcase
  end

  // R2: configuration is frozen while a copy runs
  a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && regWrEn) |=> ($stable(srcBase) && $stable(dstBase) && $stable(dstCntBase) && $stable(mode)));
  // R5: each write lowers the destination count by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDst && !strobe.reload && !cfgWr) |=> (dstCnt == $past(dstCnt) - CNT_W'(1)));
  // R9: hold-source keeps the source address fixed
  a_r9_hold_src: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTmp && mode[3]) |=> $stable(srcAddr));
  // R10: the source address does not move during a write cycle
  a_r10_src_still_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.phaseWr && !strobe.reload) |=> $stable(srcAddr));
endmodule

// File: rtl/copyControl.sv
module copyControl
  import copyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastXfer,
  input  logic       autoInit,
  output copyStrobeT strobe,
  output logic       idle,
  output logic       memRd,
  output logic       memWr,
  output logic       busy,
  output logic       eop
);
  copyStateT state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      eop   <= 1'b0;
    end else begin
      eop <= (state == ST_WRITE) && lastXfer;
      case (state)
        ST_IDLE:  if (start) state <= ST_READ;
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: state <= lastXfer ? ST_IDLE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign idle  = (state == ST_IDLE);
  assign busy  = !idle;
  assign memRd = (state == ST_READ);
  assign memWr = (state == ST_WRITE);

  always_comb begin
    strobe.loadTmp = memRd;
    strobe.stepDst = memWr;
    strobe.reload  = memWr && lastXfer && autoInit;
    strobe.phaseWr = memWr;
  end

  // R3: read and write cycles never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));
  // R3: a read cycle is always followed by its write cycle
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rstN) memRd |=> memWr);
  // R6: an accepted start raises busy
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R6: eop follows a write and coincides with idle
  a_r6_eop_ends: assert property (@(posedge clk) disable iff (!rstN)
    eop |-> (!busy && $past(memWr)));
  // R5: the wrapping write ends the copy with eop
  a_r5_eop_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && lastXfer) |=> eop);
  // R7: start during a copy does not restart the read phase
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && start) |=> !memRd);
endmodule

// File: rtl/blkCopyEngine.sv
module blkCopyEngine
  import copyPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              busy,
  output logic              eop
);
  copyStrobeT strobe;
  logic idle, lastXfer, autoInit;

  copyControl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .lastXfer(lastXfer), .autoInit(autoInit),
    .strobe(strobe), .idle(idle), .memRd(memRd), .memWr(memWr), .busy(busy), .eop(eop)
  );

  copyDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .REG_W(REG_W)) uDp (
    .clk(clk), .rstN(rstN), .idle(idle), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe), .memRData(memRData),
    .memAddr(memAddr), .tmpData(memWData), .lastXfer(lastXfer), .autoInit(autoInit)
  );
endmodule

// File: tb/blkCopyEngine_test.sv
module blkCopyEngine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        start = 1'b0;
  logic [15:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWData, memRData;
  logic        busy, eop;
  logic [7:0]  mem [256];
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  blkCopyEngine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .start(start), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWData(memWData), .memRData(memRData), .busy(busy), .eop(eop)
  );

  assign memRData = mem[memAddr[7:0]];
  always @(posedge clk) if (memWr) mem[memAddr[7:0]] <= memWData;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [15:0] val);
    regSel = sel; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] sel, input logic [15:0] exp);
    regSel = sel; #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic setup(input logic [15:0] sa, input logic [15:0] da, input logic [15:0] cnt,
                       input logic [3:0] md);
    wrReg(3'd0, sa); wrReg(3'd2, da); wrReg(3'd3, cnt); wrReg(3'd4, {12'd0, md});
  endtask

  // pulse start, count negedges until eop
  task automatic runCopy(input string tag, input int expCycles);
    int n = 0;
    start = 1'b1;
    while (n < 2000) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (eop) break;
    end
    chk(tag, n, expCycles);
    chk({tag, " busy low at eop"}, busy, 1'b0);
    @(negedge clk);
    chk({tag, " eop single pulse"}, eop, 1'b0);
  endtask

  task automatic tReset();
    chk("R1 busy", busy, 1'b0);
    chk("R1 eop", eop, 1'b0);
    chk("R1 memRd", memRd, 1'b0);
    chk("R1 memWr", memWr, 1'b0);
    for (int s = 0; s < 5; s++) rdChk("R1 reg zero", 3'(s), 16'h0);
  endtask

  task automatic tBasic();
    for (int i = 0; i < 8; i++) mem[8'h10 + i] = 8'hA0 + 8'(i);
    for (int i = 0; i < 8; i++) mem[8'h40 + i] = 8'h00;
    setup(16'h0010, 16'h0040, 16'd3, 4'b0000);
    rdChk("R2 src addr loaded", 3'd0, 16'h0010);
    rdChk("R2 dst count loaded", 3'd3, 16'h0003);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R6 busy after start", busy, 1'b1);
    chk("R3 read cycle", memRd, 1'b1);
    chk("R3 read addr", memAddr, 16'h0010);
    chk("R3 no write in read", memWr, 1'b0);
    rdChk("R10 dst cnt unchanged in read", 3'd3, 16'h0003);
    @(negedge clk);
    chk("R3 write cycle", memWr, 1'b1);
    chk("R3 write addr", memAddr, 16'h0040);
    chk("R3 write data", memWData, 8'hA0);
    rdChk("R10 src stepped after read", 3'd0, 16'h0011);
    rdChk("R10 dst not yet stepped", 3'd2, 16'h0040);
    // remaining cycles: total 9 negedges to eop from start
    begin
      int n = 2;
      while (n < 100) begin
        @(negedge clk); n++;
        if (eop) break;
      end
      chk("R6 cycles to eop count 3", n, 9);
    end
    for (int i = 0; i < 4; i++) chk("R5 copied data", mem[8'h40 + i], 8'hA0 + 8'(i));
    chk("R5 no extra write", mem[8'h44], 8'h00);
    rdChk("R8 count wrapped", 3'd3, 16'hFFFF);
    rdChk("R8 dst addr final", 3'd2, 16'h0044);
    rdChk("R4 src addr final", 3'd0, 16'h0014);
    @(negedge clk);
  endtask

  task automatic tDecrement();
    for (int i = 0; i < 4; i++) mem[8'h20 + i] = 8'h30 + 8'(i);
    for (int i = 0; i < 5; i++) mem[8'h80 + i] = 8'hEE;
    setup(16'h0023, 16'h0083, 16'd2, 4'b0011);
    runCopy("R4 decrement timing", 7);
    chk("R4 dec d83", mem[8'h83], 8'h33);
    chk("R4 dec d82", mem[8'h82], 8'h32);
    chk("R4 dec d81", mem[8'h81], 8'h31);
    chk("R4 dec d80 untouched", mem[8'h80], 8'hEE);
    rdChk("R4 src addr down", 3'd0, 16'h0020);
  endtask

  task automatic tFill();
    mem[8'h50] = 8'h5A; mem[8'h51] = 8'h11;
    for (int i = 0; i < 6; i++) mem[8'h90 + i] = 8'h00;
    setup(16'h0050, 16'h0090, 16'd4, 4'b1000);
    runCopy("R9 fill timing", 11);
    for (int i = 0; i < 5; i++) chk("R9 fill value", mem[8'h90 + i], 8'h5A);
    chk("R9 fill end", mem[8'h95], 8'h00);
    rdChk("R9 src fixed", 3'd0, 16'h0050);
  endtask

  task automatic tAutoInit();
    mem[8'h10] = 8'h61; mem[8'h11] = 8'h62;
    setup(16'h0010, 16'h00A0, 16'd1, 4'b0100);
    wrReg(3'd1, 16'h0077);
    runCopy("R8 auto timing", 5);
    chk("R8 auto data0", mem[8'hA0], 8'h61);
    chk("R8 auto data1", mem[8'hA1], 8'h62);
    rdChk("R8 reload dst count", 3'd3, 16'h0001);
    rdChk("R8 reload dst addr", 3'd2, 16'h00A0);
    rdChk("R8 reload src addr", 3'd0, 16'h0010);
    rdChk("R8 reload src count", 3'd1, 16'h0077);
    mem[8'h10] = 8'h71; mem[8'h11] = 8'h72;
    runCopy("R8 rerun timing", 5);
    chk("R8 rerun data0", mem[8'hA0], 8'h71);
    chk("R8 rerun data1", mem[8'hA1], 8'h72);
  endtask

  task automatic tStartBusy();
    int n = 0;
    setup(16'h0000, 16'h00C0, 16'd5, 4'b0000);
    start = 1'b1;
    while (n < 200) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (n == 3 || n == 6) begin
        start = 1'b1;
        regSel = 3'd2; regWrData = 16'h00F0; regWrEn = 1'b1;
      end else regWrEn = 1'b0;
      if (eop) break;
    end
    start = 1'b0; regWrEn = 1'b0;
    chk("R7 start while busy ignored", n, 13);
    rdChk("R2 busy write ignored", 3'd2, 16'h00C6);
    @(negedge clk);
    chk("R7 no restart", busy, 1'b0);
  endtask

  task automatic tSingle();
    mem[8'h05] = 8'h9C; mem[8'hB0] = 8'h00; mem[8'hB1] = 8'h00;
    setup(16'h0005, 16'h00B0, 16'd0, 4'b0000);
    runCopy("R5 count zero one datum", 3);
    chk("R5 single data", mem[8'hB0], 8'h9C);
    chk("R5 single only", mem[8'hB1], 8'h00);
    rdChk("R5 single wrap", 3'd3, 16'hFFFF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #1;
    tReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tDecrement();
    tFill();
    tAutoInit();
    tStartBusy();
    tSingle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule